// File: doc/BRIEF.md
# Call-Level Banked Register File with Asymmetric Argument and Result Registers

This block is the register file of a small processor whose 16-bit instructions can name only sixteen registers. It keeps a physical bank of registers for each call level, up to a parameterised number of levels. A call strobe moves a depth pointer one level deeper and a return strobe moves it back. Because each level has its own storage, a caller's working registers survive a call without any save code. The argument and result registers are asymmetric: the value the current level reads from one of them is not the value it last wrote there, but the value written by the level next to it.

Indices 0 to 6 are private working registers for each level, and indices 7 to 9 are one shared set. Writes to 10 to 13 load outgoing arguments for the next callee, and reads of 10 to 13 return the arguments the caller passed in. Writes to 14 to 15 load outgoing results for the caller, and reads of 14 to 15 return what the last finished callee produced. There are two combinational read ports and one write port that is applied on the clock edge. When a call arrives at the deepest bank or a return arrives at level zero, a status output pulses and the pointer holds its value. A spill engine outside the block can use these pulses to move banks to memory.

Top module: `cwrf_top`

## Requirements
- R1: After reset the depth output is 0, both flags are low, and every index reads 0.
- R2: Indices 0–6 read the current level's last write to them. A caller's values are intact after its callee returns, and a newly entered level reads 0 in all of them.
- R3: Indices 7–9 are a single set: a value written at any level is read back at every level.
- R4: A write to indices 10–13 never changes what the writing level reads there. A level at depth d>0 reads the values that level d−1 wrote to 10–13, and level 0 reads 0.
- R5: A write to indices 14–15 never changes what the writing level reads there. A level reads the values the most recently returned callee wrote to 14–15, and it reads 0 until a callee has returned since that level was entered.
- R6: A lone call adds 1 to the depth and a lone return subtracts 1. A call and a return in the same cycle leave the depth unchanged. The write in any cycle is applied at the depth held before that cycle's update.
- R7: A lone call at depth NBANK−1 (7 by default) raises the overflow output in the same cycle, and the depth stays unchanged.
- R8: A lone return at depth 0 raises the underflow output in the same cycle, and the depth stays 0.
- R9: A read of an index in the same cycle that the index is written returns the value it held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Enter a deeper call level |
| ret_i | input | 1 | Return to the calling level |
| we_i | input | 1 | Write enable |
| waddr_i | input | 4 | Write index |
| wdata_i | input | DW | Write data |
| raddr_a_i | input | 4 | Read index, port A |
| rdata_a_o | output | DW | Read data, port A (combinational) |
| raddr_b_i | input | 4 | Read index, port B |
| rdata_b_o | output | DW | Read data, port B (combinational) |
| depth_o | output | $clog2(NBANK) | Current call depth |
| ovf_o | output | 1 | Call refused at the deepest bank |
| unf_o | output | 1 | Return refused at level 0 |

## Verification
The bench fills all sixteen indices at level 0 with distinct values. It then reads them back through a call and a return, which separates private, shared, argument and result storage: a class that was wired to the wrong bank returns another class's value. It also walks down a marker chain to the deepest bank and back. There, every level's argument read must equal its parent's marker, and every result read must equal its child's marker, which exposes an off-by-one bank offset or a missing clear. A combined call-and-return cycle that carries a write, a refused call, a refused return, and a write with a read of the same index in one cycle each test a single rule: pre-update write depth, saturation, and the absence of bypass.

// File: rtl/cwrf_pkg.sv
package cwrf_pkg;
    localparam int ARCH_REGS = 16;
    localparam int LOC_CNT   = 7;
    localparam int GLB_CNT   = 3;
    localparam int ARG_CNT   = 4;
    localparam int RES_CNT   = 2;
    localparam int GLB_BASE  = LOC_CNT;
    localparam int ARG_BASE  = GLB_BASE + GLB_CNT;
    localparam int RES_BASE  = ARG_BASE + ARG_CNT;

    typedef enum logic [1:0] {
        CLS_LOCAL,
        CLS_GLOBAL,
        CLS_ARG,
        CLS_RES
    } reg_cls_e;
endpackage

// File: rtl/cwrf_decode.sv
module cwrf_decode
    import cwrf_pkg::*;
(
    input  logic [3:0] idx_i,
    output reg_cls_e   cls_o,
    output logic [2:0] off_o
);
    always_comb begin
        if (int'(idx_i) < GLB_BASE) begin
            cls_o = CLS_LOCAL;
            off_o = idx_i[2:0];
        end else if (int'(idx_i) < ARG_BASE) begin
            cls_o = CLS_GLOBAL;
            off_o = 3'(idx_i - 4'(GLB_BASE));
        end else if (int'(idx_i) < RES_BASE) begin
            cls_o = CLS_ARG;
            off_o = 3'(idx_i - 4'(ARG_BASE));
        end else begin
            cls_o = CLS_RES;
            off_o = 3'(idx_i - 4'(RES_BASE));
        end
    end
endmodule

// File: rtl/cwrf_depth.sv
module cwrf_depth #(
    parameter int NBANK = 8,
    localparam int DPW  = $clog2(NBANK),
    localparam int MAXD = NBANK - 1
) (
    input  logic           call_i,
    input  logic           ret_i,
    input  logic [DPW-1:0] depth_q_i,
    output logic [DPW-1:0] depth_d_o,
    output logic           enter_o,
    output logic           ovf_o,
    output logic           unf_o
);
    logic lone_call, lone_ret, at_top, at_bot;

    always_comb begin
        lone_call = call_i & ~ret_i;
        lone_ret  = ret_i & ~call_i;
        at_top    = (depth_q_i == DPW'(MAXD));
        at_bot    = (depth_q_i == '0);
        ovf_o     = lone_call & at_top;
        unf_o     = lone_ret & at_bot;
        enter_o   = lone_call & ~at_top;
        depth_d_o = depth_q_i;
        if (enter_o)
            depth_d_o = depth_q_i + DPW'(1);
        else if (lone_ret && !at_bot)
            depth_d_o = depth_q_i - DPW'(1);
    end
endmodule

// File: rtl/cwrf_read_port.sv
module cwrf_read_port
    import cwrf_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int DW    = 16,
    localparam int DPW  = $clog2(NBANK),
    localparam int MAXD = NBANK - 1
) (
    input  logic [3:0]                             raddr_i,
    input  logic [DPW-1:0]                         depth_i,
    input  logic [NBANK-1:0][LOC_CNT-1:0][DW-1:0]  loc_i,
    input  logic [GLB_CNT-1:0][DW-1:0]             glob_i,
    input  logic [NBANK-1:0][ARG_CNT-1:0][DW-1:0]  arg_i,
    input  logic [NBANK-1:0][RES_CNT-1:0][DW-1:0]  res_i,
    output logic [DW-1:0]                          rdata_o
);
    reg_cls_e   cls;
    logic [2:0] off;

    cwrf_decode u_dec (
        .idx_i (raddr_i),
        .cls_o (cls),
        .off_o (off)
    );

    always_comb begin
        rdata_o = '0;
        unique case (cls)
            CLS_LOCAL:  rdata_o = loc_i[depth_i][off];
            CLS_GLOBAL: rdata_o = glob_i[off[1:0]];
            CLS_ARG: begin
                if (depth_i != '0)
                    rdata_o = arg_i[depth_i - DPW'(1)][off[1:0]];
            end
            CLS_RES: begin
                if (depth_i != DPW'(MAXD))
                    rdata_o = res_i[depth_i + DPW'(1)][off[0]];
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cwrf_top.sv
module cwrf_top
    import cwrf_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int DW    = 16,
    localparam int DPW  = $clog2(NBANK),
    localparam int MAXD = NBANK - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic           we_i,
    input  logic [3:0]     waddr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [3:0]     raddr_a_i,
    output logic [DW-1:0]  rdata_a_o,
    input  logic [3:0]     raddr_b_i,
    output logic [DW-1:0]  rdata_b_o,
    output logic [DPW-1:0] depth_o,
    output logic           ovf_o,
    output logic           unf_o
);
    typedef struct packed {
        logic [DPW-1:0]                         depth;
        logic [NBANK-1:0][LOC_CNT-1:0][DW-1:0]  loc;
        logic [NBANK-1:0][ARG_CNT-1:0][DW-1:0]  arg;
        logic [NBANK-1:0][RES_CNT-1:0][DW-1:0]  res;
        logic [GLB_CNT-1:0][DW-1:0]             glob;
    } state_t;

    state_t st_d, st_q;

    logic [DPW-1:0] depth_nx;
    logic           enter;
    reg_cls_e       wcls;
    logic [2:0]     woff;

    cwrf_depth #(.NBANK(NBANK)) u_depth (
        .call_i    (call_i),
        .ret_i     (ret_i),
        .depth_q_i (st_q.depth),
        .depth_d_o (depth_nx),
        .enter_o   (enter),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    cwrf_decode u_wdec (
        .idx_i (waddr_i),
        .cls_o (wcls),
        .off_o (woff)
    );

    logic [1:0][3:0]    rd_addr;
    logic [1:0][DW-1:0] rd_data;

    assign rd_addr[0] = raddr_a_i;
    assign rd_addr[1] = raddr_b_i;

    for (genvar p = 0; p < 2; p++) begin : g_rport
        cwrf_read_port #(.NBANK(NBANK), .DW(DW)) u_rp (
            .raddr_i (rd_addr[p]),
            .depth_i (st_q.depth),
            .loc_i   (st_q.loc),
            .glob_i  (st_q.glob),
            .arg_i   (st_q.arg),
            .res_i   (st_q.res),
            .rdata_o (rd_data[p])
        );
    end

    assign rdata_a_o = rd_data[0];
    assign rdata_b_o = rd_data[1];
    assign depth_o   = st_q.depth;

    always_comb begin
        int nb;
        st_d       = st_q;
        st_d.depth = depth_nx;
        nb         = int'(st_q.depth) + 1;

        // entering level nb: wipe its private, outgoing-arg and outgoing-result
        // banks, plus the result bank it will read from its own callees
        if (enter && nb <= MAXD) begin
            st_d.loc[nb] = '0;
            st_d.arg[nb] = '0;
            st_d.res[nb] = '0;
            if (nb + 1 <= MAXD)
                st_d.res[nb + 1] = '0;
        end

        // the write lands at the depth held before this cycle's update
        if (we_i) begin
            unique case (wcls)
                CLS_LOCAL:  st_d.loc[st_q.depth][woff]     = wdata_i;
                CLS_GLOBAL: st_d.glob[woff[1:0]]           = wdata_i;
                CLS_ARG:    st_d.arg[st_q.depth][woff[1:0]] = wdata_i;
                CLS_RES:    st_d.res[st_q.depth][woff[0]]  = wdata_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/cwrf_checker.sv
module cwrf_checker #(
    parameter int NBANK = 8,
    parameter int DW    = 16,
    localparam int DPW  = $clog2(NBANK),
    localparam int MAXD = NBANK - 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           call_i,
    input logic           ret_i,
    input logic           we_i,
    input logic [3:0]     waddr_i,
    input logic [DW-1:0]  wdata_i,
    input logic [3:0]     raddr_a_i,
    input logic [DW-1:0]  rdata_a_o,
    input logic [3:0]     raddr_b_i,
    input logic [DW-1:0]  rdata_b_o,
    input logic [DPW-1:0] depth_o,
    input logic           ovf_o,
    input logic           unf_o
);
    p_local_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i <= 4'd6 && !call_i && !ret_i) |=>
        (raddr_a_i != $past(waddr_i) || rdata_a_o == $past(wdata_i)));

    p_glob_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i >= 4'd7 && waddr_i <= 4'd9) |=>
        (raddr_a_i != $past(waddr_i) || rdata_a_o == $past(wdata_i)));

    p_arg_top_zero_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o == '0 && raddr_a_i >= 4'd10 && raddr_a_i <= 4'd13) |-> rdata_a_o == '0);

    p_arg_top_zero_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o == '0 && raddr_b_i >= 4'd10 && raddr_b_i <= 4'd13) |-> rdata_b_o == '0);

    p_call_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !ovf_o) |=> depth_o == $past(depth_o) + DPW'(1));

    p_ret_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !unf_o) |=> depth_o == $past(depth_o) - DPW'(1));

    p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(depth_o));

    p_ovf_at_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> depth_o == DPW'(MAXD));

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> $stable(depth_o));

    p_unf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> depth_o == '0);
endmodule

bind cwrf_top cwrf_checker #(.NBANK(NBANK), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .we_i      (we_i),
    .waddr_i   (waddr_i),
    .wdata_i   (wdata_i),
    .raddr_a_i (raddr_a_i),
    .rdata_a_o (rdata_a_o),
    .raddr_b_i (raddr_b_i),
    .rdata_b_o (rdata_b_o),
    .depth_o   (depth_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
);

// File: tb/cwrf_top_test.sv
module cwrf_top_test;
    localparam int NB   = 8;
    localparam int DW   = 16;
    localparam int DPW  = $clog2(NB);
    localparam int MAXD = NB - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           call_i = 1'b0, ret_i = 1'b0, we_i = 1'b0;
    logic [3:0]     waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
    logic [DW-1:0]  wdata_i = '0;
    logic [DW-1:0]  rdata_a_o, rdata_b_o;
    logic [DPW-1:0] depth_o;
    logic           ovf_o, unf_o;

    always #10 clk = ~clk;

    cwrf_top #(.NBANK(NB), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
        .raddr_a_i(raddr_a_i), .rdata_a_o(rdata_a_o),
        .raddr_b_i(raddr_b_i), .rdata_b_o(rdata_b_o),
        .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // behavioural stack model
    logic [DW-1:0] mloc [NB][7];
    logic [DW-1:0] marg [NB][4];
    logic [DW-1:0] mres [NB][2];
    logic [DW-1:0] mret [NB][2];
    logic [DW-1:0] mglob [3];
    int            mdepth;

    typedef struct {
        int            kind;   // 0 port A, 1 port B, 2 depth, 3 ovf, 4 unf
        string         tag;
        logic [DW-1:0] exp;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    function automatic logic [DW-1:0] mread(int a);
        if (a < 7)       return mloc[mdepth][a];
        else if (a < 10) return mglob[a-7];
        else if (a < 14) return (mdepth == 0) ? '0 : marg[mdepth-1][a-10];
        else             return mret[mdepth][a-14];
    endfunction

    task automatic model_reset();
        for (int l = 0; l < NB; l++) begin
            for (int i = 0; i < 7; i++) mloc[l][i] = '0;
            for (int i = 0; i < 4; i++) marg[l][i] = '0;
            for (int i = 0; i < 2; i++) begin mres[l][i] = '0; mret[l][i] = '0; end
        end
        for (int i = 0; i < 3; i++) mglob[i] = '0;
        mdepth = 0;
    endtask

    task automatic model_apply(bit c, bit r, bit w, int wa, logic [DW-1:0] wd);
        if (w) begin
            if (wa < 7)       mloc[mdepth][wa] = wd;
            else if (wa < 10) mglob[wa-7] = wd;
            else if (wa < 14) marg[mdepth][wa-10] = wd;
            else              mres[mdepth][wa-14] = wd;
        end
        if (c && !r && mdepth < MAXD) begin
            mdepth++;
            for (int i = 0; i < 7; i++) mloc[mdepth][i] = '0;
            for (int i = 0; i < 4; i++) marg[mdepth][i] = '0;
            for (int i = 0; i < 2; i++) begin mres[mdepth][i] = '0; mret[mdepth][i] = '0; end
        end else if (r && !c && mdepth > 0) begin
            for (int i = 0; i < 2; i++) mret[mdepth-1][i] = mres[mdepth][i];
            mdepth--;
        end
    endtask

    task automatic push(int k, string tag, logic [DW-1:0] e);
        item_t it;
        it.kind = k; it.tag = tag; it.exp = e;
        sb.push_back(it);
    endtask

    // drive one cycle of control/write; flags expected combinationally
    task automatic step(bit c, bit r, bit w, int wa, logic [DW-1:0] wd, string tag);
        @(negedge clk);
        call_i = c; ret_i = r; we_i = w; waddr_i = wa[3:0]; wdata_i = wd;
        push(3, tag, DW'(c && !r && mdepth == MAXD));
        push(4, tag, DW'(r && !c && mdepth == 0));
        @(posedge clk);
        model_apply(c, r, w, wa, wd);
    endtask

    task automatic wr(int wa, logic [DW-1:0] wd, string tag);
        step(0, 0, 1, wa, wd, tag);
    endtask

    task automatic chk(int a, int b, string tag);
        @(negedge clk);
        call_i = 0; ret_i = 0; we_i = 0;
        raddr_a_i = a[3:0]; raddr_b_i = b[3:0];
        push(0, tag, mread(a));
        push(1, tag, mread(b));
        push(2, tag, DW'(mdepth));
    endtask

    // write and read the same index in one cycle
    task automatic wr_rd(int wa, logic [DW-1:0] wd, string tag);
        @(negedge clk);
        call_i = 0; ret_i = 0; we_i = 1; waddr_i = wa[3:0]; wdata_i = wd;
        raddr_a_i = wa[3:0];
        push(0, tag, mread(wa));
        @(posedge clk);
        model_apply(0, 0, 1, wa, wd);
    endtask

    // monitor: compare queued expectations mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                item_t it;
                logic [DW-1:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = rdata_a_o;
                    1: act = rdata_b_o;
                    2: act = DW'(depth_o);
                    3: act = DW'(ovf_o);
                    default: act = DW'(unf_o);
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk(0, 10, "R1");
        chk(14, 7, "R1");
        step(0, 0, 0, 0, '0, "R1");

        // fill every index at level 0
        for (int i = 0; i < 16; i++) wr(i, DW'(16'h1000 + i), "R2");
        chk(10, 14, "R4");
        chk(11, 15, "R5");
        chk(3, 8, "R2");

        // one call, probe all classes
        step(1, 0, 0, 0, '0, "R6");
        chk(10, 11, "R4");
        chk(12, 13, "R4");
        chk(0, 6, "R2");
        chk(7, 9, "R3");
        chk(14, 15, "R5");
        wr(10, 16'hAAAA, "R4");
        chk(10, 13, "R4");
        wr(14, 16'hBEEF, "R5");
        wr(15, 16'hCAFE, "R5");
        chk(14, 15, "R5");
        wr(2, 16'h2222, "R2");
        wr(8, 16'h8888, "R3");
        step(0, 1, 0, 0, '0, "R6");
        chk(14, 15, "R5");
        chk(2, 8, "R2");
        chk(8, 7, "R3");

        // call and return together with a write
        step(1, 1, 1, 5, 16'h5555, "R6");
        chk(5, 0, "R6");

        // descend to the deepest bank and one beyond
        for (int l = 0; l <= MAXD; l++) begin
            wr(10, DW'(16'h0A00 + l), "R4");
            wr(0, DW'(16'h0C00 + l), "R2");
            step(1, 0, 0, 0, '0, "R7");
            chk(10, 0, "R4");
            chk(7, 14, "R3");
        end

        // climb back, each level leaving a result
        for (int d = MAXD; d >= 1; d--) begin
            wr(14, DW'(16'hE000 + d), "R5");
            step(0, 1, 0, 0, '0, "R6");
            chk(14, 0, "R5");
            chk(10, 1, "R2");
        end
        step(0, 1, 0, 0, '0, "R8");
        chk(0, 14, "R8");

        // R9: no same-cycle bypass
        wr_rd(3, 16'h3333, "R9");
        chk(3, 9, "R9");
        wr_rd(9, 16'h9999, "R9");
        chk(9, 3, "R9");

        @(negedge clk);
        @(negedge clk);
        #8;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule